// File: doc/BRIEF.md
# NAND Bus Strobe Sequencer

This block drives an 8-bit asynchronous external-memory bus that has NAND flash devices on it. A host asks for one byte transfer at a time through a request/acknowledge handshake. The block turns each request into a timed sequence of chip-select, write-enable and read-enable strobes. A byte write drives data onto the bus. A byte read captures data from the bus and returns it with the acknowledge.

Each phase has its own length: setup, strobe and hold, set separately for reads and for writes, plus a turnaround gap. All of these lengths come from one packed 32-bit timing word. The length of a phase is counted in interface clock cycles. The command-latch and address-latch enables are decoded from two fixed host address bits. They are driven only when the selected chip select has its NAND mode bit set. All attached devices share one wired-AND ready/busy line. The block synchronises that line and reports it as a ready status bit.

Top module: `nand_strobe_seq`

## Requirements
- R1: A write uses write setup = cfg[29:26], write strobe = cfg[25:20] and write hold = cfg[19:17]. The phases last setup+1, strobe+1 and hold+1 cycles. The selected chip select is low for all three phases. `bus_we_n` is low only during the strobe phase, and `bus_re_n` stays high.
- R2: A read uses read setup = cfg[16:13], read strobe = cfg[12:7] and read hold = cfg[6:4], with the same +1 rule. `bus_re_n` is low only during the strobe phase, and `bus_we_n` stays high.
- R3: On a read, the byte on `bus_din` is captured at the clock edge that ends the last strobe cycle. It is shown on `rdata` while `ack` is high.
- R4: `ack` is high for exactly one cycle, which is the last cycle of the hold phase. The block accepts the first request one cycle after `req` is seen in the idle state.
- R5: When an access reverses the direction of the previous access (read after write, or write after read), turnaround = cfg[3:2] adds cfg[3:2]+1 cycles before setup. During those cycles all chip selects and strobes are inactive. No gap is added for the same direction, or for the first access after reset.
- R6: `bus_cle` follows host address bit 4. `bus_ale` follows address bit 3 when bit 4 is clear, so CLE takes priority. Both are driven only while the chip select is active, and only when `cs_mode[req_cs]` is 1 (NAND mode).
- R7: During a write, `bus_doe` is high and `bus_dout` carries the write byte for the whole setup/strobe/hold span. `bus_doe` is low at all other times.
- R8: cfg bits 31, 30, 1 and 0 have no effect on timing. They are the strobe-mode select, the extended-wait enable and the bus-size field, and for an 8-bit NAND bus they are 0.
- R9: `dev_ready` equals `wait_in` delayed by two clock edges, through a two-flop synchronizer.
- R10: In reset, all chip selects, `bus_we_n` and `bus_re_n` are high. `bus_cle`, `bus_ale`, `bus_doe`, `ack` and `dev_ready` are low.
- R11: At most one chip select is low at any time, and it is the one given in `req_cs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Packed timing word (fields in R1, R2, R5, R8) |
| cs_mode | input | CS_NUM | NAND-mode bit per chip select |
| req | input | 1 | Access request, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_cs | input | log2(CS_NUM) | Chip select index |
| req_addr | input | ADDR_W | Host byte address |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | Access complete |
| rdata | output | 8 | Captured read byte |
| bus_cs_n | output | CS_NUM | Active-low chip selects |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_re_n | output | 1 | Active-low read strobe |
| bus_cle | output | 1 | Command latch enable |
| bus_ale | output | 1 | Address latch enable |
| bus_addr | output | ADDR_W | Latched address lines |
| bus_dout | output | 8 | Data to the bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 8 | Data from the bus |
| wait_in | input | 1 | Shared wired-AND ready/busy line |
| dev_ready | output | 1 | Synchronised ready status |

## Verification
Some rules are checked by assertions on every cycle: strobe exclusivity, at most one chip select low, strobes only inside a chip-select window, a one-cycle acknowledge, latch enables silent while deselected, the output enable never coinciding with a read strobe, and the two-stage ready delay. Only the bench scenarios can show that each phase lasts its field value plus one. They also show that turnaround appears only on a direction change, that the captured byte is the one present in the last strobe cycle, and that the mode and bus-size bits leave timing unchanged. These need the configuration word and the bench's own phase model.

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq #(
  parameter int CS_NUM  = 4,
  parameter int ADDR_W  = 8,
  parameter int ALE_BIT = 3,
  parameter int CLE_BIT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [31:0]               cfg_word,
  input  logic [CS_NUM-1:0]         cs_mode,
  input  logic                      req,
  input  logic                      req_we,
  input  logic [$clog2(CS_NUM)-1:0] req_cs,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [7:0]                req_wdata,
  output logic                      ack,
  output logic [7:0]                rdata,
  output logic [CS_NUM-1:0]         bus_cs_n,
  output logic                      bus_we_n,
  output logic                      bus_re_n,
  output logic                      bus_cle,
  output logic                      bus_ale,
  output logic [ADDR_W-1:0]         bus_addr,
  output logic [7:0]                bus_dout,
  output logic                      bus_doe,
  input  logic [7:0]                bus_din,
  input  logic                      wait_in,
  output logic                      dev_ready
);
  localparam int CS_W = $clog2(CS_NUM);

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_SETUP, S_STRB, S_HOLD} st_t;

  st_t              st;
  logic [5:0]       cnt;
  logic [29:2]      cfg_q;
  logic             we_q, seen_q;
  logic [CS_W-1:0]  cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]       wd_q;
  logic [1:0]       rdy_sync;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_word[31:30], cfg_word[1:0]};

  logic [5:0] setup_len, strb_len, hold_len, setup_new;
  assign setup_len = we_q   ? {2'b0, cfg_q[29:26]}  : {2'b0, cfg_q[16:13]};
  assign strb_len  = we_q   ? cfg_q[25:20]          : cfg_q[12:7];
  assign hold_len  = we_q   ? {3'b0, cfg_q[19:17]}  : {3'b0, cfg_q[6:4]};
  assign setup_new = req_we ? {2'b0, cfg_word[29:26]} : {2'b0, cfg_word[16:13]};

  wire last = (cnt == 6'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      cfg_q  <= '0;
      we_q   <= 1'b0;
      seen_q <= 1'b0;
      cs_q   <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      rdata  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          cfg_q  <= cfg_word[29:2];
          we_q   <= req_we;
          cs_q   <= req_cs;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          seen_q <= 1'b1;
          if (seen_q && (we_q != req_we)) begin
            st  <= S_TURN;
            cnt <= {4'b0, cfg_word[3:2]};
          end else begin
            st  <= S_SETUP;
            cnt <= setup_new;
          end
        end
        S_TURN: if (last) begin
          st  <= S_SETUP;
          cnt <= setup_len;
        end else cnt <= cnt - 6'd1;
        S_SETUP: if (last) begin
          st  <= S_STRB;
          cnt <= strb_len;
        end else cnt <= cnt - 6'd1;
        S_STRB: if (last) begin
          if (!we_q) rdata <= bus_din;
          st  <= S_HOLD;
          cnt <= hold_len;
        end else cnt <= cnt - 6'd1;
        S_HOLD: if (last) st <= S_IDLE;
                else cnt <= cnt - 6'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_sync <= 2'b00;
    else        rdy_sync <= {rdy_sync[0], wait_in};
  end
  assign dev_ready = rdy_sync[1];

  wire active   = (st == S_SETUP) || (st == S_STRB) || (st == S_HOLD);
  wire nand_sel = cs_mode[cs_q];

  assign bus_cs_n = active ? ~(CS_NUM'(1) << cs_q) : '1;
  assign bus_we_n = !((st == S_STRB) && we_q);
  assign bus_re_n = !((st == S_STRB) && !we_q);
  assign bus_cle  = active && nand_sel && addr_q[CLE_BIT];
  assign bus_ale  = active && nand_sel && addr_q[ALE_BIT] && !addr_q[CLE_BIT];
  assign bus_addr = addr_q;
  assign bus_doe  = active && we_q;
  assign bus_dout = wd_q;
  assign ack      = (st == S_HOLD) && last;
endmodule

module nand_strobe_seq_chk #(
  parameter int CS_NUM = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic [CS_NUM-1:0] bus_cs_n,
  input logic              bus_we_n,
  input logic              bus_re_n,
  input logic              bus_cle,
  input logic              bus_ale,
  input logic              bus_doe,
  input logic              wait_in,
  input logic              dev_ready
);
  logic [1:0] age;
  logic       w1, w2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0; w1 <= 1'b0; w2 <= 1'b0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      w1 <= wait_in;
      w2 <= w1;
    end
  end

  // R4
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!bus_we_n && !bus_re_n));
  // R11
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~bus_cs_n));
  // R2
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n || !bus_re_n) |-> !(&bus_cs_n));
  // R6
  latch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&bus_cs_n) |-> (!bus_cle && !bus_ale));
  // R6
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bus_cle && bus_ale));
  // R7
  doe_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_doe |-> bus_re_n);
  // R9
  ready_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (dev_ready == w2));
endmodule

bind nand_strobe_seq nand_strobe_seq_chk #(.CS_NUM(CS_NUM)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .bus_cs_n(bus_cs_n),
  .bus_we_n(bus_we_n), .bus_re_n(bus_re_n), .bus_cle(bus_cle),
  .bus_ale(bus_ale), .bus_doe(bus_doe), .wait_in(wait_in),
  .dev_ready(dev_ready)
);

// File: tb/nand_strobe_seq_bench.sv
module nand_strobe_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [3:0]  cs_mode = '0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [1:0]  req_cs = '0;
  logic [7:0]  req_addr = '0, req_wdata = '0, bus_din = '0;
  logic        wait_in = 1'b0;
  logic        ack, bus_we_n, bus_re_n, bus_cle, bus_ale, bus_doe, dev_ready;
  logic [7:0]  rdata, bus_addr, bus_dout;
  logic [3:0]  bus_cs_n;

  always #4 clk = ~clk;

  nand_strobe_seq u_nand_strobe_seq (.*);

  int checks = 0, fails = 0;
  bit have_last = 0, last_we = 0;

  task automatic check(input bit ok, input string req_tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] din_at(input int k);
    return 8'h5A ^ 8'(k * 37);
  endfunction

  task automatic access(input bit we, input logic [1:0] cs, input logic [7:0] addr,
                        input logic [7:0] wd, input logic [31:0] cfg, input logic [3:0] mode);
    int t, s, p, h, k, bad, ack_k, first_bad;
    logic [3:0] exp_cs;
    logic exp_we, exp_re, exp_cle, exp_ale, exp_doe, act, nsel;
    logic [7:0] got_rd;
    t = (have_last && last_we != we) ? int'(cfg[3:2]) + 1 : 0;
    s = we ? int'(cfg[29:26]) + 1 : int'(cfg[16:13]) + 1;
    p = we ? int'(cfg[25:20]) + 1 : int'(cfg[12:7]) + 1;
    h = we ? int'(cfg[19:17]) + 1 : int'(cfg[6:4]) + 1;
    have_last = 1; last_we = we;
    nsel = mode[cs];
    @(negedge clk);
    cfg_word = cfg; cs_mode = mode; req = 1; req_we = we; req_cs = cs;
    req_addr = addr; req_wdata = wd;
    @(posedge clk);
    bad = 0; ack_k = -1; first_bad = -1; got_rd = '0;
    for (int i = 0; i < 200; i++) begin
      k = i;
      @(negedge clk);
      act     = (k >= t) && (k < t + s + p + h);
      exp_cs  = act ? ~(4'b1 << cs) : 4'hF;
      exp_we  = !(we && k >= t + s && k < t + s + p);
      exp_re  = !(!we && k >= t + s && k < t + s + p);
      exp_cle = act && nsel && addr[4];
      exp_ale = act && nsel && addr[3] && !addr[4];
      exp_doe = act && we;
      if (bus_cs_n !== exp_cs || bus_we_n !== exp_we || bus_re_n !== exp_re ||
          bus_cle !== exp_cle || bus_ale !== exp_ale || bus_doe !== exp_doe ||
          (exp_doe && bus_dout !== wd) || (act && bus_addr !== addr)) begin
        bad++;
        if (first_bad < 0) first_bad = k;
      end
      bus_din = din_at(k);
      if (ack === 1'b1) begin
        ack_k = k; got_rd = rdata; req = 0;
        break;
      end
    end
    // R1 R2 R5 R6 R7 R11 per-cycle strobe picture
    check(bad == 0, we ? "R1/R5/R6/R7/R11" : "R2/R5/R6/R11",
          "strobe sequence mismatch at cycle", first_bad, 0);
    // R4
    check(ack_k == t + s + p + h - 1, "R4", "ack cycle", ack_k, t + s + p + h - 1);
    // R3
    if (!we) check(got_rd === din_at(t + s + p - 1), "R3", "read byte", got_rd, din_at(t + s + p - 1));
  endtask

  function automatic logic [31:0] mk_cfg(input int ws, wst, wh, rs, rst, rh, ta);
    return {2'b00, 4'(ws), 6'(wst), 3'(wh), 4'(rs), 6'(rst), 3'(rh), 2'(ta), 2'b00};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R10
    check(bus_cs_n === 4'hF && bus_we_n === 1'b1 && bus_re_n === 1'b1, "R10", "strobes in reset",
          {bus_cs_n, bus_we_n, bus_re_n}, 6'h3F);
    check(!bus_cle && !bus_ale && !bus_doe && !ack && !dev_ready, "R10", "flags in reset",
          {bus_cle, bus_ale, bus_doe, ack, dev_ready}, 0);
    rst_n = 1;
    @(negedge clk);

    // R9 synchronizer delay
    wait_in = 1;
    @(negedge clk);
    check(dev_ready === 1'b0, "R9", "ready after one edge", dev_ready, 0);
    @(negedge clk);
    check(dev_ready === 1'b1, "R9", "ready after two edges", dev_ready, 1);
    wait_in = 0;
    @(negedge clk);
    check(dev_ready === 1'b1, "R9", "busy after one edge", dev_ready, 1);
    @(negedge clk);
    check(dev_ready === 1'b0, "R9", "busy after two edges", dev_ready, 0);

    // R1 R5: first write, no turnaround; all-minimum phases
    access(1, 2'd0, 8'h10, 8'hC3, mk_cfg(0, 0, 0, 0, 0, 0, 3), 4'hF);
    // R1 R5: write after write, no turnaround
    access(1, 2'd1, 8'h08, 8'h3C, mk_cfg(2, 3, 1, 1, 1, 1, 3), 4'hF);
    // R2 R3 R5: read after write, turnaround of 4 cycles
    access(0, 2'd2, 8'h00, 8'h00, mk_cfg(1, 1, 1, 3, 5, 2, 3), 4'hF);
    // R6 CLE priority over ALE when both bits set
    access(0, 2'd3, 8'h18, 8'h00, mk_cfg(1, 1, 1, 0, 2, 0, 0), 4'hF);
    // R6 mode bit cleared: no latch enables
    access(1, 2'd1, 8'h18, 8'h99, mk_cfg(0, 1, 0, 0, 0, 0, 1), 4'b1101);
    // R8 strobe-mode, ext-wait and bus-size bits set: same timing
    access(1, 2'd0, 8'h08, 8'h11, mk_cfg(1, 2, 1, 0, 0, 0, 2) | 32'hC000_0003, 4'hF);
    access(0, 2'd0, 8'h10, 8'h00, mk_cfg(0, 0, 0, 2, 3, 1, 2) | 32'hC000_0003, 4'hF);
    // R1 R2 maximum fields
    access(1, 2'd2, 8'h00, 8'hA5, mk_cfg(15, 63, 7, 15, 63, 7, 3), 4'hF);
    access(0, 2'd2, 8'h08, 8'h00, mk_cfg(15, 63, 7, 15, 63, 7, 3), 4'hF);

    for (int n = 0; n < 60; n++) begin
      logic [31:0] c;
      c = $urandom;
      access(1'($urandom), 2'($urandom), 8'($urandom), 8'($urandom), c, 4'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule